// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Force

This block sits after a PWM time base and compare unit and decides, tick by tick, the level of two PWM outputs, A and B. Each tick it examines the shared counter. It notes whether the counter has reached zero, whether it has reached the period value, and whether it has reached either compare value while counting up. For each output, a programmable control word assigns one of four actions to each of these events: leave the level alone, drive it low, drive it high, or invert it.

A continuous force can override either output and hold it at a fixed level whatever the events request. Software writes new force codes into a shadow copy. A reload-mode field chooses when that shadow copy becomes active: at counter zero, at counter period, at either of the two, or on the very next tick. The usual set-up programs zero and period to drive high and compare-up to drive low, which gives an active-high waveform whose high time in ticks equals the compare value.

Top module: `pwm_action_qual`

## Requirements
- R1: After a synchronous active-low reset both outputs are low, every action field is "no action" (00), no force is active, the force reload mode is 00, and a tick at counter zero leaves both outputs low.
- R2: Action codes are 00 no change, 01 drive low, 10 drive high, 11 invert. Register address 0 holds the control word for output A and address 1 the one for output B. In each word, bits 1:0 give the action at counter zero and bits 3:2 the action at counter equal to period.
- R3: In the same control word, bits 5:4 give the action when the counter equals compare A and bits 9:8 the action when the counter equals compare B. Both apply only while the direction input reads 1 (counting up), so a match while counting down has no effect. All other bits of the word are ignored.
- R4: Outputs change only on clock cycles where the tick input is 1. With tick at 0 they hold their level, whatever the counter shows.
- R5: When several events with an action other than 00 hit one output on the same tick, exactly one action applies. Compare A wins over compare B, compare B over period, and period over zero.
- R6: Register address 2 is the force register. Bits 1:0 are the force code for A and bits 3:2 the code for B. Code 01 forces low, 10 forces high, and 00 and 11 mean no force. While a force code is active, the output keeps the forced level on every tick regardless of its event actions.
- R7: Bits 7:6 of the force register select when written force codes become active. 00 means at a counter-zero tick, 01 at a counter-period tick, 10 at either, and 11 at the next tick. On the tick where the new codes become active they already decide the output; until then the previous codes stay in force.
- R8: Once a release (code 00 or 11) becomes active, the output resumes from its forced level and follows its event actions again from that same tick.
- R9: With zero and period set to drive high and compare-up set to drive low, one up-count period of 0..P shows the output high for exactly C ticks, where C is the compare value, and high again after the period tick.
- R10: The two outputs are independent. Writes to one control word never change the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tb_tick_i | input | 1 | Time-base tick enable; events are evaluated only when set |
| tb_cnt_i | input | CNT_W | Time-base counter value |
| tb_up_i | input | 1 | Counter direction, 1 = counting up |
| tb_prd_i | input | CNT_W | Period value |
| cmp_a_i | input | CNT_W | Compare A value |
| cmp_b_i | input | CNT_W | Compare B value |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control A, 1 control B, 2 force |
| cfg_wdata_i | input | CFG_W | Register write data |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8) and the default 16-bit register word. This keeps every counter value it drives, a period of 10 and compare points 4, 7, 5 and 10, small and written out, while the upper control-word bits can still be filled with set bits that must be ignored. The small period makes it possible to step through a whole up-count period tick by tick and count the high ticks on both outputs. Zero, period and compare values can also be aliased (period 0, compare equal to period, both compares equal) to exercise every priority pairing and every reload mode of the force register.

// File: rtl/pwm_aq_pkg.sv
// Package: shared types for the PWM action qualifier.
// Holds the action and reload-mode encodings, the event bundle and
// the register address map used by every module of the block.
package pwm_aq_pkg;

    // Per-event action encoding.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } aq_act_e;

    // When shadowed force codes move into the active copy.
    typedef enum logic [1:0] {
        LD_ZERO   = 2'b00,
        LD_PERIOD = 2'b01,
        LD_EITHER = 2'b10,
        LD_NOW    = 2'b11
    } aq_load_e;

    // Force codes (00 and 11 both release).
    localparam logic [1:0] FRC_LOW  = 2'b01;
    localparam logic [1:0] FRC_HIGH = 2'b10;

    // Tick-qualified time-base events.
    typedef struct packed {
        logic zero;
        logic period;
        logic cmp_a_up;
        logic cmp_b_up;
    } aq_events_t;

    // Register addresses.
    localparam logic [1:0] ADDR_CTL_A = 2'd0;
    localparam logic [1:0] ADDR_CTL_B = 2'd1;
    localparam logic [1:0] ADDR_FORCE = 2'd2;

    // Number of PWM outputs handled by the block.
    localparam int unsigned NUM_OUT = 2;

endpackage

// File: rtl/pwm_aq_event_det.sv
// Module: pwm_aq_event_det
// Derives the four time-base events from the counter, period and
// compare values. Each event is qualified by the tick enable; compare
// events additionally require the counter to be counting up.
// Assumes all inputs are stable and synchronous to the block clock.
module pwm_aq_event_det
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             up_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output aq_events_t       ev_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    // Compare the counter against each reference and gate with tick.
    always_comb begin
        ev_o.zero     = tick_i && (cnt_i == CNT_ZERO);
        ev_o.period   = tick_i && (cnt_i == prd_i);
        ev_o.cmp_a_up = tick_i && up_i && (cnt_i == cmp_a_i);
        ev_o.cmp_b_up = tick_i && up_i && (cnt_i == cmp_b_i);
    end

endmodule

// File: rtl/pwm_aq_force_ctl.sv
// Module: pwm_aq_force_ctl
// Holds the continuous force register: a reload mode, a shadow copy of
// the force codes and the active copy. Writes land in the shadow copy
// and the mode field at once; the shadow moves to the active copy on
// the tick selected by the mode. On the loading tick the shadow codes
// are already presented as the effective force.
// Assumes events arrive tick-qualified from pwm_aq_event_det.
module pwm_aq_force_ctl
    import pwm_aq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  aq_events_t ev_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [2*NUM_OUT-1:0] force_o
);

    aq_load_e               mode_q;
    logic [2*NUM_OUT-1:0]   shadow_q;
    logic [2*NUM_OUT-1:0]   active_q;
    logic                   load;

    // Bits 5:4 of the force word carry nothing.
    logic unused_force_bits;
    assign unused_force_bits = ^wdata_i[5:4];

    // Decide whether this tick moves the shadow into the active copy.
    always_comb begin
        unique case (mode_q)
            LD_ZERO:   load = ev_i.zero;
            LD_PERIOD: load = ev_i.period;
            LD_EITHER: load = ev_i.zero || ev_i.period;
            default:   load = tick_i;
        endcase
    end

    // Register writes and shadow-to-active transfer.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q   <= LD_ZERO;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_i) begin
                mode_q   <= aq_load_e'(wdata_i[7:6]);
                shadow_q <= wdata_i[2*NUM_OUT-1:0];
            end
            if (load) begin
                active_q <= shadow_q;
            end
        end
    end

    // Effective force: the shadow codes win on the loading tick.
    assign force_o = load ? shadow_q : active_q;

    // R7: in next-tick mode every tick copies the shadow.
    a_r7_now_mode_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && mode_q == LD_NOW) |=> (active_q == $past(shadow_q)))
        else $error("force shadow not loaded in next-tick mode");

    // R7: in zero mode the active copy waits for a zero tick.
    a_r7_zero_mode_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == LD_ZERO && !(tick_i && ev_i.zero)) |=> $stable(active_q))
        else $error("force active copy changed outside zero tick");

    // R7: in period mode the active copy waits for a period tick.
    a_r7_period_mode_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == LD_PERIOD && !(tick_i && ev_i.period)) |=> $stable(active_q))
        else $error("force active copy changed outside period tick");

endmodule

// File: rtl/pwm_aq_chan.sv
// Module: pwm_aq_chan
// One PWM output: its action control word and output register. On each
// tick, the highest-priority event with an action other than "none"
// decides the next level (compare A > compare B > period > zero); an
// active force code overrides that result.
// Assumes CFG_W >= 11 so that all action fields fit in the word.
module pwm_aq_chan
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  aq_events_t       ev_i,
    input  logic             ctl_we_i,
    input  logic [CFG_W-1:0] ctl_wdata_i,
    input  logic [1:0]       force_i,
    output logic             q_o
);

    aq_act_e act_zero_q;
    aq_act_e act_prd_q;
    aq_act_e act_ca_q;
    aq_act_e act_cb_q;
    aq_act_e act_sel;
    logic    lvl_evt;
    logic    lvl_next;

    // Bits of the control word that carry no field.
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_wdata_i[CFG_W-1:10], ctl_wdata_i[7:6]};

    // Capture the action fields on a write to this channel's word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_zero_q <= ACT_NONE;
            act_prd_q  <= ACT_NONE;
            act_ca_q   <= ACT_NONE;
            act_cb_q   <= ACT_NONE;
        end else if (ctl_we_i) begin
            act_zero_q <= aq_act_e'(ctl_wdata_i[1:0]);
            act_prd_q  <= aq_act_e'(ctl_wdata_i[3:2]);
            act_ca_q   <= aq_act_e'(ctl_wdata_i[5:4]);
            act_cb_q   <= aq_act_e'(ctl_wdata_i[9:8]);
        end
    end

    // Pick the winning action, lowest priority first so later ones override.
    always_comb begin
        act_sel = ACT_NONE;
        if (ev_i.zero && act_zero_q != ACT_NONE)   act_sel = act_zero_q;
        if (ev_i.period && act_prd_q != ACT_NONE)  act_sel = act_prd_q;
        if (ev_i.cmp_b_up && act_cb_q != ACT_NONE) act_sel = act_cb_q;
        if (ev_i.cmp_a_up && act_ca_q != ACT_NONE) act_sel = act_ca_q;
    end

    // Apply the winning action, then the force override.
    always_comb begin
        unique case (act_sel)
            ACT_LOW:    lvl_evt = 1'b0;
            ACT_HIGH:   lvl_evt = 1'b1;
            ACT_TOGGLE: lvl_evt = ~q_o;
            default:    lvl_evt = q_o;
        endcase
        if (force_i == FRC_LOW)       lvl_next = 1'b0;
        else if (force_i == FRC_HIGH) lvl_next = 1'b1;
        else                          lvl_next = lvl_evt;
    end

    // Output register, advanced only on ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     q_o <= 1'b0;
        else if (tick_i) q_o <= lvl_next;
    end

    // R4: no tick, no change.
    a_r4_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(q_o))
        else $error("output moved without a tick");

    // R6: forced low is low after the tick.
    a_r6_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && force_i == FRC_LOW) |=> !q_o)
        else $error("forced-low output is high");

    // R6: forced high is high after the tick.
    a_r6_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && force_i == FRC_HIGH) |=> q_o)
        else $error("forced-high output is low");

    // R2: without any event and force the level holds across a tick.
    a_r2_idle_tick_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ev_i == '0 && force_i != FRC_LOW && force_i != FRC_HIGH)
        |=> $stable(q_o))
        else $error("output moved on a tick with no event");

endmodule

// File: rtl/pwm_action_qual.sv
// Module: pwm_action_qual (top)
// Two-output PWM action qualifier. Detects time-base events, keeps the
// continuous force register and drives one channel per output. Register
// writes: address 0 control A, 1 control B, 2 force; address 3 ignored.
// Assumes a single clock and a synchronous active-low reset.
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tb_tick_i,
    input  logic [CNT_W-1:0] tb_cnt_i,
    input  logic             tb_up_i,
    input  logic [CNT_W-1:0] tb_prd_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_addr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);

    aq_events_t            ev;
    logic [2*NUM_OUT-1:0]  force_eff;
    logic [NUM_OUT-1:0]    pwm_q;

    pwm_aq_event_det #(.CNT_W(CNT_W)) u_evt (
        .tick_i  (tb_tick_i),
        .cnt_i   (tb_cnt_i),
        .up_i    (tb_up_i),
        .prd_i   (tb_prd_i),
        .cmp_a_i (cmp_a_i),
        .cmp_b_i (cmp_b_i),
        .ev_o    (ev)
    );

    pwm_aq_force_ctl u_force (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tb_tick_i),
        .ev_i    (ev),
        .wr_i    (cfg_we_i && cfg_addr_i == ADDR_FORCE),
        .wdata_i (cfg_wdata_i[7:0]),
        .force_o (force_eff)
    );

    // One channel per output; channel index equals its control address.
    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_chan
        pwm_aq_chan #(.CFG_W(CFG_W)) u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .tick_i      (tb_tick_i),
            .ev_i        (ev),
            .ctl_we_i    (cfg_we_i && cfg_addr_i == 2'(gi)),
            .ctl_wdata_i (cfg_wdata_i),
            .force_i     (force_eff[2*gi +: 2]),
            .q_o         (pwm_q[gi])
        );
    end

    assign pwm_a_o = pwm_q[0];
    assign pwm_b_o = pwm_q[1];

    // R10: a write to A's control word leaves B unchanged on the next edge.
    a_r10_ctl_a_write_spares_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == ADDR_CTL_A && !tb_tick_i) |=> $stable(pwm_b_o))
        else $error("write to control A disturbed output B");

endmodule

// File: tb/pwm_action_qual_bench.sv
`timescale 1ns/1ps
module pwm_action_qual_bench;

    localparam int unsigned BW = 8;
    localparam int unsigned WW = 16;
    localparam int NVEC = 12;

    // {control word for A, counter, direction up, expected A}
    localparam logic [25:0] VEC [NVEC] = '{
        {16'h0002, 8'd0,  1'b1, 1'b1},   // zero -> high
        {16'h0010, 8'd4,  1'b1, 1'b0},   // cmp A up -> low
        {16'h0030, 8'd4,  1'b0, 1'b0},   // cmp A while down: ignored
        {16'h0030, 8'd4,  1'b1, 1'b1},   // cmp A up -> toggle
        {16'h0300, 8'd7,  1'b1, 1'b0},   // cmp B up -> toggle
        {16'h0008, 8'd10, 1'b1, 1'b1},   // period -> high
        {16'h0001, 8'd10, 1'b1, 1'b1},   // zero action, no zero event
        {16'h0001, 8'd0,  1'b1, 1'b0},   // zero -> low
        {16'h0003, 8'd0,  1'b1, 1'b1},   // zero -> toggle
        {16'h0003, 8'd0,  1'b1, 1'b0},   // zero -> toggle again
        {16'h0000, 8'd4,  1'b1, 1'b0},   // all none
        {16'hF0C2, 8'd0,  1'b1, 1'b1}    // spare bits set, zero -> high
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [BW-1:0] cnt = '0;
    logic          up = 1'b1;
    logic [BW-1:0] prd = 8'd10;
    logic [BW-1:0] cmpa = 8'd4;
    logic [BW-1:0] cmpb = 8'd7;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [WW-1:0] wdata = '0;
    logic          pwm_a;
    logic          pwm_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_action_qual #(.CNT_W(BW), .CFG_W(WW)) u_pwm_action_qual (
        .clk_i(clk), .rst_ni(rst_n), .tb_tick_i(tick), .tb_cnt_i(cnt),
        .tb_up_i(up), .tb_prd_i(prd), .cmp_a_i(cmpa), .cmp_b_i(cmpb),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Register write: one cycle, starting and ending at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [WW-1:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // One tick with the given counter; outputs are valid on return.
    task automatic step(input logic [BW-1:0] c, input logic dir);
        cnt = c; up = dir; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi_a;
        int hi_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and all-none actions
        chk("R1 reset A", pwm_a, 1'b0);
        chk("R1 reset B", pwm_b, 1'b0);
        step(8'd0, 1'b1);
        chk("R1 none at zero A", pwm_a, 1'b0);
        chk("R1 none at zero B", pwm_b, 1'b0);

        // R2 R3: table of single-event actions on output A
        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            wr(2'd0, v[25:10]);
            step(v[9:2], v[1]);
            chk($sformatf("R2 R3 vector %0d", i), pwm_a, v[0]);
        end
        chk("R10 B untouched", pwm_b, 1'b0);

        // R5: coincident events
        cmpa = 8'd10;
        wr(2'd0, 16'h0018);
        step(8'd10, 1'b1);
        chk("R5 compare over period (low)", pwm_a, 1'b0);
        wr(2'd0, 16'h0024);
        step(8'd10, 1'b1);
        chk("R5 compare over period (high)", pwm_a, 1'b1);
        prd = 8'd0;
        wr(2'd0, 16'h0006);
        step(8'd0, 1'b1);
        chk("R5 period over zero", pwm_a, 1'b0);
        prd = 8'd10; cmpa = 8'd5; cmpb = 8'd5;
        wr(2'd0, 16'h0120);
        step(8'd5, 1'b1);
        chk("R5 compare A over compare B", pwm_a, 1'b1);
        cmpa = 8'd4; cmpb = 8'd7;

        // R6 R7 R8: force on output B
        wr(2'd1, 16'h010A);
        wr(2'd2, 16'h00C4);
        step(8'd0, 1'b1);
        chk("R7 next-tick force low", pwm_b, 1'b0);
        wr(2'd2, 16'h0008);
        step(8'd3, 1'b1);
        chk("R7 zero mode waits", pwm_b, 1'b0);
        step(8'd0, 1'b1);
        chk("R7 zero mode loads high", pwm_b, 1'b1);
        step(8'd7, 1'b1);
        chk("R6 forced high ignores compare", pwm_b, 1'b1);
        wr(2'd2, 16'h0040);
        step(8'd7, 1'b1);
        chk("R7 period mode release waits", pwm_b, 1'b1);
        step(8'd10, 1'b1);
        chk("R8 release at period", pwm_b, 1'b1);
        step(8'd7, 1'b1);
        chk("R8 actions resume", pwm_b, 1'b0);
        step(8'd10, 1'b1);
        chk("R8 period high", pwm_b, 1'b1);
        wr(2'd2, 16'h0084);
        step(8'd5, 1'b1);
        chk("R7 either mode waits", pwm_b, 1'b1);
        step(8'd10, 1'b1);
        chk("R7 either mode loads at period", pwm_b, 1'b0);
        wr(2'd2, 16'h008C);
        step(8'd5, 1'b1);
        chk("R6 code 11 waits for load", pwm_b, 1'b0);
        step(8'd0, 1'b1);
        chk("R6 code 11 releases at zero", pwm_b, 1'b1);

        // R4: no tick, no change
        cnt = 8'd7; up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 hold without tick", pwm_b, 1'b1);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset A", pwm_a, 1'b0);
        chk("R1 re-reset B", pwm_b, 1'b0);
        step(8'd0, 1'b1);
        chk("R1 actions cleared B", pwm_b, 1'b0);

        // R9: canonical waveform over one period on both outputs
        wr(2'd0, 16'h001A);
        wr(2'd1, 16'h010A);
        hi_a = 0; hi_b = 0;
        for (int c = 0; c < 10; c++) begin
            step(BW'(c), 1'b1);
            hi_a += int'(pwm_a);
            hi_b += int'(pwm_b);
        end
        chk("R9 A high ticks equal compare A", hi_a == 4, 1'b1);
        chk("R9 B high ticks equal compare B", hi_b == 7, 1'b1);
        step(8'd10, 1'b1);
        chk("R9 A high after period", pwm_a, 1'b1);
        chk("R9 B high after period", pwm_b, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule